// File: doc/BRIEF.md
# Single-Key Sentence Sequencer

This block decides which sentence a single push-button plays. It takes clean, single-cycle key-press events and turns each one into one or more playback requests for a separate playback engine. Each request is a sentence index plus a one-cycle start pulse. The block then watches the engine's busy and done signals to know when it may launch the next request.

Three selection behaviours are supported over a list of up to 32 sentences:
- **Step mode:** each press plays the entry after the one played last time, then stops.
- **Sweep mode:** one press plays the whole list in order.
- **Random mode:** each press plays a pseudo-randomly chosen entry.

A loop setting keeps a key's playback repeating until a stop request arrives. A stop request abandons whatever is in flight and returns the block to idle.

Top module: `key_sentence_seq`

## Requirements
- R1: While reset is asserted, and once reset has been released with no press yet, `seq_active` and `play_start` are 0 and `play_idx` is 0.
- R2: Step mode (`cfg_mode`=0). A press launches the index held by an internal step pointer, which is 0 after reset. When the engine signals done, the block goes idle. The pointer becomes index+1, or 0 when the played index was the last entry. If the pointer is not below the list length when a press arrives, entry 0 is played.
- R3: Sweep mode (`cfg_mode`=1). A press launches entries 0, 1, … up to length−1, one start pulse per entry, each after the previous done. After the last entry the block goes idle. Sweep mode leaves the step pointer untouched.
- R4: Random mode (`cfg_mode`=2). A press plays the current LFSR value modulo the list length. The LFSR is 5 bits wide and loads 1 when the internal reset is released. It then advances on every clock as next = {q[3:0], q[4]^q[2]}. The internal reset is `rst_n` passed through two flip-flops. Random mode leaves the step pointer untouched.
- R5: With `cfg_loop`=1 at the press, a done in step or random mode relaunches the same index. In sweep mode, a done on the last entry relaunches entry 0.
- R6: A `stop_req` seen while active returns the block to idle on the next cycle, without moving the step pointer. A `stop_req` in idle cancels a simultaneous press.
- R7: `play_start` is held off while `eng_busy` is 1. It is a single-cycle pulse per launch, with `play_idx` valid in the same cycle.
- R8: Presses arriving while the block is active are ignored. `play_idx` does not change and no extra start pulse is issued.
- R9: `cfg_len` of 0 is treated as 1, and values above 32 are treated as 32. Played indices are always below the effective length.
- R10: `cfg_mode`=3 behaves exactly as step mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_press | input | 1 | Debounced single-cycle press event |
| stop_req | input | 1 | Abort request |
| cfg_mode | input | 2 | 0 step, 1 sweep, 2 random, 3 step |
| cfg_loop | input | 1 | Repeat playback until stopped |
| cfg_len | input | 6 | Sentence list length |
| eng_busy | input | 1 | Engine cannot accept a start |
| eng_done | input | 1 | Engine finished the current sentence |
| play_start | output | 1 | One-cycle launch pulse |
| play_idx | output | 5 | Sentence index to play |
| seq_active | output | 1 | A sequence is in progress |

## Verification
A table of step-mode presses is applied with list lengths that shrink, drop to zero and exceed the maximum. This separates correct pointer wrap and clamping from an off-by-one in the length compare, and it also covers the alias mode value.

Sweep presses are run over a short list and over the clamped full list. These show the in-order walk, its end point, and that the step pointer is left alone.

Random presses with several lengths are compared against an independent model of the LFSR. Looped presses in each mode, each ended by a stop at a different phase, distinguish relaunch from advance and show that stopping preserves the pointer. The held-off start under busy and presses made during playback complete the picture.

// File: rtl/kss_pkg.sv
`timescale 1ns/1ps
package kss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } kss_state_e;

  typedef enum logic [1:0] {
    MD_STEP  = 2'd0,
    MD_SWEEP = 2'd1,
    MD_RAND  = 2'd2,
    MD_ALIAS = 2'd3
  } kss_mode_e;
endpackage

// File: rtl/kss_rst_sync.sv
`timescale 1ns/1ps
module kss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/kss_lfsr.sv
`timescale 1ns/1ps
module kss_lfsr #(
  parameter int         W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;

  // R4: a maximal-length register never reaches the all-zero lock-up state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/kss_pick.sv
`timescale 1ns/1ps
module kss_pick
  import kss_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_mode,
  input  logic [IDX_W-1:0] step_ptr,
  input  logic [IDX_W-1:0] rnd,
  output logic [LEN_W-1:0] eff_len,
  output logic [IDX_W-1:0] pick_idx
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] rnd_mod;
  logic             ptr_ok;

  // R9: clamp the requested length into 1..MAX_LEN
  always_comb begin
    if (cfg_len == '0)          eff_len = LEN_W'(1);
    else if (cfg_len > LEN_MAX) eff_len = LEN_MAX;
    else                        eff_len = cfg_len;
  end

  always_comb begin
    rnd_mod = LEN_W'(rnd) % eff_len;
    ptr_ok  = LEN_W'(step_ptr) < eff_len;
    unique case (kss_mode_e'(cfg_mode))
      MD_SWEEP: pick_idx = '0;
      MD_RAND:  pick_idx = rnd_mod[IDX_W-1:0];
      default:  pick_idx = ptr_ok ? step_ptr : '0;
    endcase
  end
endmodule

// File: rtl/kss_ctrl.sv
`timescale 1ns/1ps
module kss_ctrl
  import kss_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_press,
  input  logic             stop_req,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_loop,
  input  logic [LEN_W-1:0] eff_len,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             eng_busy,
  input  logic             eng_done,
  output logic             play_start,
  output logic [IDX_W-1:0] play_idx,
  output logic             seq_active,
  output logic [IDX_W-1:0] step_ptr
);
  kss_state_e       state_q, state_d;
  kss_mode_e        mode_q, mode_d;
  logic             loop_q, loop_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en, cfg_en, idx_en;
  logic             at_last;
  logic [IDX_W-1:0] idx_inc;

  assign at_last = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));
  assign idx_inc = idx_q + IDX_W'(1);

  // next-state process
  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    loop_d     = loop_q;
    len_d      = len_q;
    idx_d      = idx_q;
    ptr_d      = ptr_q;
    cfg_en     = 1'b0;
    idx_en     = 1'b0;
    ptr_en     = 1'b0;
    play_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // R6: a stop in idle cancels a simultaneous press
        if (key_press && !stop_req) begin
          state_d = ST_LAUNCH;
          mode_d  = kss_mode_e'(cfg_mode);
          loop_d  = cfg_loop;
          len_d   = eff_len;
          idx_d   = pick_idx;
          cfg_en  = 1'b1;
          idx_en  = 1'b1;
        end
      end
      ST_LAUNCH: begin
        if (stop_req) begin
          state_d = ST_IDLE;
        end else if (!eng_busy) begin      // R7
          play_start = 1'b1;
          state_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stop_req) begin
          state_d = ST_IDLE;
        end else if (eng_done) begin
          if (mode_q == MD_SWEEP) begin      // R3
            if (!at_last) begin
              idx_d   = idx_inc;
              idx_en  = 1'b1;
              state_d = ST_LAUNCH;
            end else if (loop_q) begin       // R5
              idx_d   = '0;
              idx_en  = 1'b1;
              state_d = ST_LAUNCH;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (loop_q) begin         // R5
            state_d = ST_LAUNCH;
          end else begin
            state_d = ST_IDLE;
            if (mode_q != MD_RAND) begin     // R2, R10
              ptr_d  = at_last ? '0 : idx_inc;
              ptr_en = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_STEP;
      loop_q  <= 1'b0;
      len_q   <= LEN_W'(1);
      idx_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_en) begin
        mode_q <= mode_d;
        loop_q <= loop_d;
        len_q  <= len_d;
      end
      if (idx_en) idx_q <= idx_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign play_idx   = idx_q;
  assign seq_active = (state_q != ST_IDLE);
  assign step_ptr   = ptr_q;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |=> !play_start);

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAUNCH && eng_busy && !stop_req) |=> (state_q == ST_LAUNCH));

  a_r6_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !seq_active);

  a_r6_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> $stable(ptr_q));

  a_r8_wait_holds_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !eng_done && !stop_req) |=> ($stable(play_idx) && state_q == ST_WAIT));

  a_r9_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> (LEN_W'(play_idx) < len_q));
endmodule

// File: rtl/key_sentence_seq.sv
`timescale 1ns/1ps
module key_sentence_seq #(
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_press,
  input  logic             stop_req,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_loop,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             eng_busy,
  input  logic             eng_done,
  output logic             play_start,
  output logic [IDX_W-1:0] play_idx,
  output logic             seq_active
);
  logic             rst_ni;
  logic [IDX_W-1:0] rnd;
  logic [IDX_W-1:0] step_ptr;
  logic [IDX_W-1:0] pick_idx;
  logic [LEN_W-1:0] eff_len;

  kss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  kss_lfsr #(.W(IDX_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_ni),
    .value (rnd)
  );

  kss_pick #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_pick (
    .cfg_len  (cfg_len),
    .cfg_mode (cfg_mode),
    .step_ptr (step_ptr),
    .rnd      (rnd),
    .eff_len  (eff_len),
    .pick_idx (pick_idx)
  );

  kss_ctrl #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ni),
    .key_press  (key_press),
    .stop_req   (stop_req),
    .cfg_mode   (cfg_mode),
    .cfg_loop   (cfg_loop),
    .eff_len    (eff_len),
    .pick_idx   (pick_idx),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .play_start (play_start),
    .play_idx   (play_idx),
    .seq_active (seq_active),
    .step_ptr   (step_ptr)
  );
endmodule

// File: tb/sim_key_sentence_seq.sv
`timescale 1ns/1ps
module sim_key_sentence_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       key_press, stop_req, cfg_loop, eng_busy, eng_done;
  logic [1:0] cfg_mode;
  logic [5:0] cfg_len;
  logic       play_start, seq_active;
  logic [4:0] play_idx;

  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  key_sentence_seq u0 (
    .clk(clk), .rst_n(rst_n), .key_press(key_press), .stop_req(stop_req),
    .cfg_mode(cfg_mode), .cfg_loop(cfg_loop), .cfg_len(cfg_len),
    .eng_busy(eng_busy), .eng_done(eng_done), .play_start(play_start),
    .play_idx(play_idx), .seq_active(seq_active)
  );

  // independent model of the random source described in R4
  logic       m_s1, m_s2;
  logic [4:0] m_lfsr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_s1 <= 1'b0; m_s2 <= 1'b0; end
    else        begin m_s1 <= 1'b1; m_s2 <= m_s1; end
  end
  always @(posedge clk or negedge m_s2) begin
    if (!m_s2) m_lfsr <= 5'd1;
    else       m_lfsr <= {m_lfsr[3:0], m_lfsr[4] ^ m_lfsr[2]};
  end

  // step-mode vectors: {mode[1:0], len[5:0], expected index[4:0]}
  localparam logic [12:0] VEC [0:8] = '{
    {2'd0, 6'd3,  5'd0},
    {2'd0, 6'd3,  5'd1},
    {2'd0, 6'd3,  5'd2},
    {2'd0, 6'd3,  5'd0},
    {2'd3, 6'd3,  5'd1},
    {2'd0, 6'd2,  5'd0},
    {2'd0, 6'd0,  5'd0},
    {2'd0, 6'd40, 5'd0},
    {2'd0, 6'd40, 5'd1}
  };

  function automatic int effl(input int len);
    if (len == 0) return 1;
    if (len > 32) return 32;
    return len;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input int mode, input bit lp, input int len, output int rexp);
    @(negedge clk);
    cfg_mode  = 2'(mode);
    cfg_loop  = lp;
    cfg_len   = 6'(len);
    key_press = 1'b1;
    rexp      = int'(m_lfsr) % effl(len);
    @(posedge clk); #1;
    key_press = 1'b0;
  endtask

  // called one step after a launch edge; leaves one step after the done edge
  task automatic serve(input int exp, input string req);
    check(play_start === 1'b1, req, play_start, 1);
    check(play_idx == 5'(exp), req, play_idx, exp);
    @(posedge clk); #1;
    eng_done = 1'b1;
    @(posedge clk); #1;
    eng_done = 1'b0;
  endtask

  task automatic stop_now();
    stop_req = 1'b1;
    @(posedge clk); #1;
    stop_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nchk++; nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int r;
    string tag;
    rst_n = 1'b0; key_press = 0; stop_req = 0; cfg_loop = 0;
    eng_busy = 0; eng_done = 0; cfg_mode = 0; cfg_len = 6'd1;
    repeat (3) @(posedge clk); #1;
    check(seq_active == 0 && play_start == 0, "R1", seq_active, 0);
    check(play_idx == 0, "R1", play_idx, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check(seq_active == 0 && play_start == 0 && play_idx == 0, "R1", seq_active, 0);

    // table walk: step-mode pointer, wrap, alias mode, length clamp
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][12:11] == 2'd3) tag = "R10";
      else if (VEC[i][10:5] == 0 || VEC[i][10:5] > 32) tag = "R9";
      else tag = "R2";
      press(int'(VEC[i][12:11]), 1'b0, int'(VEC[i][10:5]), r);
      serve(int'(VEC[i][4:0]), tag);
      check(seq_active == 0, tag, seq_active, 0);
    end

    // R3: sweep of four entries, pointer (2) untouched
    press(1, 1'b0, 4, r);
    for (int k = 0; k < 4; k++) serve(k, "R3");
    check(seq_active == 0, "R3", seq_active, 0);
    press(0, 1'b0, 3, r);
    serve(2, "R3");

    // R9: sweep with oversize length covers 0..31
    press(1, 1'b0, 40, r);
    for (int k = 0; k < 32; k++) serve(k, "R9");
    check(seq_active == 0, "R9", seq_active, 0);

    // R4: random picks against the model
    press(2, 1'b0, 5, r); serve(r, "R4");
    check(seq_active == 0, "R4", seq_active, 0);
    @(negedge clk);
    press(2, 1'b0, 7, r); serve(r, "R4");
    press(2, 1'b0, 1, r); serve(0, "R4");

    // R5 random loop, then stop in launch phase (R6)
    press(2, 1'b1, 6, r);
    serve(r, "R5"); serve(r, "R5");
    stop_now();
    check(seq_active == 0 && play_start == 0, "R6", seq_active, 0);

    // R5 step loop (pointer 0), stop in wait phase, pointer kept (R6)
    press(0, 1'b1, 4, r);
    serve(0, "R5"); serve(0, "R5");
    @(posedge clk); #1;
    stop_now();
    check(seq_active == 0, "R6", seq_active, 0);
    press(0, 1'b0, 4, r);
    serve(0, "R6");

    // R5 sweep loop restarts at entry 0
    press(1, 1'b1, 2, r);
    serve(0, "R5"); serve(1, "R5"); serve(0, "R5");
    stop_now();
    check(seq_active == 0, "R5", seq_active, 0);

    // R7: start held while engine busy
    eng_busy = 1'b1;
    press(0, 1'b0, 4, r);
    check(play_start == 0 && seq_active == 1, "R7", play_start, 0);
    repeat (3) @(posedge clk); #1;
    check(play_start == 0 && play_idx == 1, "R7", play_start, 0);
    eng_busy = 1'b0; #1;
    serve(1, "R7");

    // R8: press during playback ignored
    press(0, 1'b0, 4, r);
    check(play_idx == 2, "R8", play_idx, 2);
    @(posedge clk); #1;
    cfg_mode = 2'd1; cfg_len = 6'd8; key_press = 1'b1;
    @(posedge clk); #1;
    key_press = 1'b0;
    check(play_idx == 2 && play_start == 0 && seq_active == 1, "R8", play_idx, 2);
    eng_done = 1'b1;
    @(posedge clk); #1;
    eng_done = 1'b0;
    check(seq_active == 0, "R8", seq_active, 0);
    press(0, 1'b0, 4, r);
    serve(3, "R8");
    press(0, 1'b0, 4, r);
    serve(0, "R2");

    // R6: stop cancels a simultaneous press in idle
    @(negedge clk);
    key_press = 1'b1; stop_req = 1'b1;
    @(posedge clk); #1;
    key_press = 1'b0; stop_req = 1'b0;
    check(seq_active == 0 && play_start == 0, "R6", seq_active, 0);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule